// File: doc/BRIEF.md
# Indirect Memory-Controller Configuration Registers with Bank Decoder

This block is the software-visible register set of a memory controller. All of its registers are reached through two ports: a pointer port, which holds the offset of the internal register to use, and a data port, which reads or writes the register the pointer selects. The register set covers the following:

- a global configuration word and a read-only status word that follows it;
- two error status words, which hardware sets and software clears by writing ones;
- an error address word;
- refresh, power-management and timing words;
- an ECC configuration word and an ECC error status word, which drives an interrupt line;
- one configuration word per memory bank.

Each bank configuration word carries three fields: a base address, a size code and an enable. A combinational decoder uses them to report which active bank a system address falls into. The decoder only reports a bank while the controller is globally enabled.

The access port is a plain single-cycle register port. A write takes effect at the clock edge where `acc_wr` is high. A read is combinational, so `acc_rdata` shows the current content of the port that `acc_port` selects. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `sdr_cfg_top`

## Requirements
- R1: A write with `acc_port`=0 loads the pointer from the low 8 bits of `acc_wdata`, and a read with `acc_port`=0 returns the pointer zero-extended. A write with `acc_port`=1 updates the register that the pointer selects, and a read with `acc_port`=1 returns that register. The offsets are:
  - 0x00: error status A
  - 0x08: error status B
  - 0x10: error address
  - 0x20: configuration
  - 0x24: status
  - 0x30: refresh
  - 0x34: power management
  - 0x40, 0x44, 0x48, 0x4C: banks 0 to 3
  - 0x80: timing
  - 0x94: ECC configuration
  - 0x98: ECC error status
- R2: After reset, the registers hold the following values, and every other register, including the pointer, reads 0:
  - configuration: 0x00800000
  - refresh: 0x05F00000
  - power management: 0x07C00000
  - timing: 0x00854009
- R3: Writes are masked as follows. Bits outside the mask are stored as 0.
  - refresh: 0x3FF80000
  - timing: 0x018FC01F
  - ECC configuration: 0x00F00000
  - each bank word: 0xFFDEE001
  - power management: bits 31:27 are taken from the write and bits 26:22 are forced to 1.
  - configuration, error address and ECC error status: the whole word is stored.
- R4: A configuration write that takes bit 31 from 0 to 1 clears status bit 31. A configuration write that takes bit 31 from 1 to 0 sets status bit 31.
- R5: Status bit 30 follows configuration bit 30 after every configuration write. Writes to the status offset have no effect.
- R6: Each bit of an error status word is set by the matching bit of `err_set_a` or `err_set_b`. A data-port write clears each bit written as 1. A set on the same cycle as a clear wins.
- R7: `ecc_irq` is high exactly while the ECC error status word is nonzero. It rises in the cycle after a nonzero write to that word and falls in the cycle after a zero write.
- R8: In each bank word, bits 31:23 are the base address bits 31:23, bits 19:17 give the size code k (the bank covers 4 MiB shifted left by k), and bit 0 is the bank enable. Bank bit i of `bank_hit` is high only when configuration bit 31 is set, that bank's enable is set, and base ≤ `dec_addr` ≤ base + size − 1.
- R9: When several banks match, only the lowest-numbered one is reported, so `bank_hit` is always one-hot or zero.
- R10: A read at any offset not listed in R1 returns 0. A write at such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_port | input | 1 | Port select: 0 = pointer, 1 = data |
| acc_wr | input | 1 | Write strobe for the selected port |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the selected port (combinational) |
| err_set_a | input | 32 | Per-bit set pulses for error status A |
| err_set_b | input | 32 | Per-bit set pulses for error status B |
| dec_addr | input | 32 | System address to decode |
| bank_hit | output | 4 | One-hot bank match, lowest bank first |
| ecc_irq | output | 1 | ECC error interrupt |

## Verification
The hardest situation to reach is a hardware set and a software clear landing on the same error-status bit in the same cycle. To produce it, the stimulus raises `err_set_a` in the very cycle of the clearing data write, then reads the word back to confirm the bit survived. Overlapping banks are also awkward to reach. The stimulus builds them by programming one large bank with base 0 under two smaller banks. It then probes addresses inside both regions, in the gap between them, and just past each upper bound. Finally, it turns the global enable off and checks that every hit disappears.

// File: rtl/sdr_cfg_pkg.sv
package sdr_cfg_pkg;
  localparam int unsigned PTR_W  = 8;
  localparam int unsigned WORD_W = 32;

  localparam logic [PTR_W-1:0] OFS_ERR_A   = 8'h00;
  localparam logic [PTR_W-1:0] OFS_ERR_B   = 8'h08;
  localparam logic [PTR_W-1:0] OFS_ERR_ADR = 8'h10;
  localparam logic [PTR_W-1:0] OFS_CONFIG  = 8'h20;
  localparam logic [PTR_W-1:0] OFS_STATUS  = 8'h24;
  localparam logic [PTR_W-1:0] OFS_REFRESH = 8'h30;
  localparam logic [PTR_W-1:0] OFS_PWR     = 8'h34;
  localparam logic [PTR_W-1:0] OFS_BANK0   = 8'h40;
  localparam logic [PTR_W-1:0] OFS_TIMING  = 8'h80;
  localparam logic [PTR_W-1:0] OFS_ECC_CFG = 8'h94;
  localparam logic [PTR_W-1:0] OFS_ECC_ST  = 8'h98;

  localparam logic [WORD_W-1:0] MSK_REFRESH = 32'h3FF8_0000;
  localparam logic [WORD_W-1:0] MSK_TIMING  = 32'h018F_C01F;
  localparam logic [WORD_W-1:0] MSK_ECC_CFG = 32'h00F0_0000;
  localparam logic [WORD_W-1:0] MSK_BANK    = 32'hFFDE_E001;
  localparam logic [WORD_W-1:0] MSK_PWR_KEEP = 32'hF800_0000;
  localparam logic [WORD_W-1:0] PWR_FORCED   = 32'h07C0_0000;

  localparam logic [WORD_W-1:0] RST_CONFIG  = 32'h0080_0000;
  localparam logic [WORD_W-1:0] RST_REFRESH = 32'h05F0_0000;
  localparam logic [WORD_W-1:0] RST_PWR     = 32'h07C0_0000;
  localparam logic [WORD_W-1:0] RST_TIMING  = 32'h0085_4009;

  // bank word field positions (decoded by the bank matcher)
  localparam int unsigned BANK_BASE_LSB = 23;
  localparam int unsigned BANK_SIZE_LSB = 17;
  localparam int unsigned BANK_SIZE_W   = 3;
  localparam int unsigned BANK_EN_BIT   = 0;
  localparam int unsigned MIN_BANK_LOG2 = 22;  // 4 MiB
endpackage

// File: rtl/sdr_cfg_regfile.sv
module sdr_cfg_regfile
  import sdr_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_port,
  input  logic                acc_wr,
  input  logic [WORD_W-1:0]   acc_wdata,
  output logic [WORD_W-1:0]   acc_rdata,
  input  logic [WORD_W-1:0]   err_set_a,
  input  logic [WORD_W-1:0]   err_set_b,
  output logic                glob_en,
  output logic [WORD_W-1:0]   bank_word [NUM_BANKS],
  output logic                ecc_irq
);
  logic [PTR_W-1:0]  ptr_q;
  logic [WORD_W-1:0] err_a_q, err_b_q, err_adr_q, config_q, status_q;
  logic [WORD_W-1:0] refresh_q, pwr_q, timing_q, ecc_cfg_q, ecc_st_q;
  logic [WORD_W-1:0] bank_q [NUM_BANKS];
  logic              data_wr;
  logic [WORD_W-1:0] sel_word;

  assign data_wr = acc_wr & acc_port;

  function automatic logic [PTR_W-1:0] bank_ofs(input int unsigned idx);
    return OFS_BANK0 + PTR_W'(4 * idx);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      err_a_q   <= '0;
      err_b_q   <= '0;
      err_adr_q <= '0;
      config_q  <= RST_CONFIG;
      status_q  <= '0;
      refresh_q <= RST_REFRESH;
      pwr_q     <= RST_PWR;
      timing_q  <= RST_TIMING;
      ecc_cfg_q <= '0;
      ecc_st_q  <= '0;
    end else begin
      if (acc_wr && !acc_port) ptr_q <= acc_wdata[PTR_W-1:0];
      if (data_wr && ptr_q == OFS_ERR_A) err_a_q <= (err_a_q & ~acc_wdata) | err_set_a;
      else                               err_a_q <= err_a_q | err_set_a;
      if (data_wr && ptr_q == OFS_ERR_B) err_b_q <= (err_b_q & ~acc_wdata) | err_set_b;
      else                               err_b_q <= err_b_q | err_set_b;
      if (data_wr) begin
        unique case (ptr_q)
          OFS_ERR_ADR: err_adr_q <= acc_wdata;
          OFS_CONFIG: begin
            config_q <= acc_wdata;
            if (!config_q[31] && acc_wdata[31])      status_q[31] <= 1'b0;
            else if (config_q[31] && !acc_wdata[31]) status_q[31] <= 1'b1;
            status_q[30] <= acc_wdata[30];
          end
          OFS_REFRESH: refresh_q <= acc_wdata & MSK_REFRESH;
          OFS_PWR:     pwr_q     <= (acc_wdata & MSK_PWR_KEEP) | PWR_FORCED;
          OFS_TIMING:  timing_q  <= acc_wdata & MSK_TIMING;
          OFS_ECC_CFG: ecc_cfg_q <= acc_wdata & MSK_ECC_CFG;
          OFS_ECC_ST:  ecc_st_q  <= acc_wdata;
          default: ;
        endcase
      end
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              bank_q[b] <= '0;
      else if (data_wr && ptr_q == bank_ofs(b)) bank_q[b] <= acc_wdata & MSK_BANK;
    end
    assign bank_word[b] = bank_q[b];
  end

  always_comb begin
    sel_word = '0;
    case (ptr_q)
      OFS_ERR_A:   sel_word = err_a_q;
      OFS_ERR_B:   sel_word = err_b_q;
      OFS_ERR_ADR: sel_word = err_adr_q;
      OFS_CONFIG:  sel_word = config_q;
      OFS_STATUS:  sel_word = status_q;
      OFS_REFRESH: sel_word = refresh_q;
      OFS_PWR:     sel_word = pwr_q;
      OFS_TIMING:  sel_word = timing_q;
      OFS_ECC_CFG: sel_word = ecc_cfg_q;
      OFS_ECC_ST:  sel_word = ecc_st_q;
      default: begin
        for (int i = 0; i < NUM_BANKS; i++)
          if (ptr_q == bank_ofs(i)) sel_word = bank_q[i];
      end
    endcase
  end

  assign acc_rdata = acc_port ? sel_word : WORD_W'(ptr_q);
  assign glob_en   = config_q[31];
  assign ecc_irq   = |ecc_st_q;

  // R5: status only moves after a configuration write
  assert_status_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_q) |-> $past(data_wr && ptr_q == OFS_CONFIG));

  // R6: an error bit can only appear where a set pulse was present
  assert_err_set_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_a_q & ~$past(err_a_q) & ~$past(err_set_a)) == '0) &&
    ((err_b_q & ~$past(err_b_q) & ~$past(err_set_b)) == '0));

  // R7: interrupt rises only after a nonzero write to the ECC error word
  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ecc_irq) |-> $past(data_wr && ptr_q == OFS_ECC_ST && acc_wdata != '0));

  // R4: status bit 31 set only when the enable is dropped
  assert_disable_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[31]) |-> $fell(config_q[31]));
endmodule

// File: rtl/sdr_bank_match.sv
module sdr_bank_match
  import sdr_cfg_pkg::*;
(
  input  logic              glob_en,
  input  logic [WORD_W-1:0] bank_word,
  input  logic [WORD_W-1:0] addr,
  output logic              match
);
  logic [WORD_W:0] base_ext, addr_ext, span, offset;
  logic [BANK_SIZE_W-1:0] size_code;

  assign size_code = bank_word[BANK_SIZE_LSB +: BANK_SIZE_W];
  assign base_ext  = {1'b0, bank_word[WORD_W-1:BANK_BASE_LSB], {BANK_BASE_LSB{1'b0}}};
  assign addr_ext  = {1'b0, addr};
  assign span      = (WORD_W+1)'(1) << (MIN_BANK_LOG2 + 32'(size_code));
  assign offset    = addr_ext - base_ext;
  assign match     = glob_en && bank_word[BANK_EN_BIT] &&
                     (addr_ext >= base_ext) && (offset < span);
endmodule

// File: rtl/sdr_bank_decoder.sv
module sdr_bank_decoder
  import sdr_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 glob_en,
  input  logic [WORD_W-1:0]    bank_word [NUM_BANKS],
  input  logic [WORD_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] bank_hit
);
  logic [NUM_BANKS-1:0] raw;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_match
    sdr_bank_match u_match (
      .glob_en  (glob_en),
      .bank_word(bank_word[b]),
      .addr     (addr),
      .match    (raw[b])
    );
  end

  // lowest-numbered match wins
  assign bank_hit = raw & ~(raw - NUM_BANKS'(1));

  assert_hit_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_hit));
  assert_hit_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_hit != '0) |-> glob_en);
endmodule

// File: rtl/sdr_cfg_top.sv
module sdr_cfg_top
  import sdr_cfg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_port,
  input  logic                 acc_wr,
  input  logic [31:0]          acc_wdata,
  output logic [31:0]          acc_rdata,
  input  logic [31:0]          err_set_a,
  input  logic [31:0]          err_set_b,
  input  logic [31:0]          dec_addr,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic                 ecc_irq
);
  logic              glob_en;
  logic [WORD_W-1:0] bank_word [NUM_BANKS];

  sdr_cfg_regfile #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc_port(acc_port), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .err_set_a(err_set_a), .err_set_b(err_set_b),
    .glob_en(glob_en), .bank_word(bank_word), .ecc_irq(ecc_irq)
  );

  sdr_bank_decoder #(.NUM_BANKS(NUM_BANKS)) u_dec (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .bank_word(bank_word),
    .addr(dec_addr), .bank_hit(bank_hit)
  );
endmodule

// File: tb/test_sdr_cfg_top.sv
module test_sdr_cfg_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_port = 0, acc_wr = 0;
  logic [31:0] acc_wdata = 0, acc_rdata;
  logic [31:0] err_set_a = 0, err_set_b = 0, dec_addr = 0;
  logic [3:0]  bank_hit;
  logic        ecc_irq;
  int          n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  sdr_cfg_top i_sdr_cfg_top (
    .clk(clk), .rst_n(rst_n), .acc_port(acc_port), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .err_set_a(err_set_a),
    .err_set_b(err_set_b), .dec_addr(dec_addr), .bank_hit(bank_hit),
    .ecc_irq(ecc_irq)
  );

  // {offset, write value, expected readback}
  localparam int NV = 10;
  localparam logic [71:0] VEC [NV] = '{
    {8'h30, 32'hFFFF_FFFF, 32'h3FF8_0000},
    {8'h80, 32'hFFFF_FFFF, 32'h018F_C01F},
    {8'h94, 32'hFFFF_FFFF, 32'h00F0_0000},
    {8'h34, 32'hFFFF_FFFF, 32'hFFC0_0000},
    {8'h34, 32'h0000_0000, 32'h07C0_0000},
    {8'h40, 32'hFFFF_FFFF, 32'hFFDE_E001},
    {8'h44, 32'h1234_5678, 32'h1214_4000},
    {8'h10, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {8'h4C, 32'h0000_0000, 32'h0000_0000},
    {8'h98, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic put(input logic port, input logic [31:0] val);
    @(negedge clk);
    acc_port = port; acc_wr = 1; acc_wdata = val;
    @(negedge clk);
    acc_wr = 0;
  endtask

  task automatic wreg(input logic [7:0] ofs, input logic [31:0] val);
    put(0, {24'h0, ofs});
    put(1, val);
  endtask

  task automatic rreg(input logic [7:0] ofs, output logic [31:0] val);
    put(0, {24'h0, ofs});
    acc_port = 1; #1; val = acc_rdata;
  endtask

  task automatic probe(input string req, input logic [31:0] a, input logic [3:0] exp);
    dec_addr = a; #1;
    check(req, {28'h0, bank_hit}, {28'h0, exp});
  endtask

  initial begin : watchdog
    #1_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: reset values
    #1; check("R2 pointer", acc_rdata, 32'h0);
    rreg(8'h20, v); check("R2 config", v, 32'h0080_0000);
    rreg(8'h30, v); check("R2 refresh", v, 32'h05F0_0000);
    rreg(8'h34, v); check("R2 power", v, 32'h07C0_0000);
    rreg(8'h80, v); check("R2 timing", v, 32'h0085_4009);
    rreg(8'h24, v); check("R2 status", v, 32'h0);
    rreg(8'h48, v); check("R2 bank2", v, 32'h0);
    check("R7 irq reset", {31'h0, ecc_irq}, 32'h0);
    // R1 pointer readback
    put(0, 32'h0000_0198); acc_port = 0; #1;
    check("R1 pointer read", acc_rdata, 32'h98);
    // R1 R3 vector walk
    for (int i = 0; i < NV; i++) begin
      wreg(VEC[i][71:64], VEC[i][63:32]);
      rreg(VEC[i][71:64], v);
      check("R3 masked write", v, VEC[i][31:0]);
    end
    // R4 R5 status tracking
    wreg(8'h20, 32'hC000_0000); rreg(8'h24, v); check("R5 st30 set", v, 32'h4000_0000);
    wreg(8'h20, 32'h0000_0000); rreg(8'h24, v); check("R4 disable", v, 32'h8000_0000);
    wreg(8'h24, 32'h0000_0000); rreg(8'h24, v); check("R5 status ro", v, 32'h8000_0000);
    wreg(8'h20, 32'h8000_0000); rreg(8'h24, v); check("R4 enable", v, 32'h0000_0000);
    // R6 write-1-to-clear
    @(negedge clk); err_set_a = 32'hF0; err_set_b = 32'h0F00_0000;
    @(negedge clk); err_set_a = 0; err_set_b = 0;
    rreg(8'h00, v); check("R6 set A", v, 32'hF0);
    wreg(8'h00, 32'h30); rreg(8'h00, v); check("R6 clear A", v, 32'hC0);
    wreg(8'h08, 32'h0100_0000); rreg(8'h08, v); check("R6 clear B", v, 32'h0E00_0000);
    put(0, 32'h00);
    @(negedge clk); acc_port = 1; acc_wr = 1; acc_wdata = 32'h40; err_set_a = 32'h40;
    @(negedge clk); acc_wr = 0; err_set_a = 0; #1;
    check("R6 set wins", acc_rdata, 32'hC0);
    // R7 interrupt
    wreg(8'h98, 32'h5); check("R7 irq rise", {31'h0, ecc_irq}, 32'h1);
    wreg(8'h98, 32'h0); check("R7 irq fall", {31'h0, ecc_irq}, 32'h0);
    // R10 undefined offset
    wreg(8'h50, 32'hFFFF_FFFF); rreg(8'h50, v); check("R10 undef read", v, 32'h0);
    rreg(8'h30, v); check("R10 refresh intact", v, 32'h3FF8_0000);
    // R8 R9 decoder (config enable already set)
    wreg(8'h40, 32'h0000_0001);
    wreg(8'h44, 32'h0082_0001);
    wreg(8'h4C, 32'h0000_0000);
    probe("R8 bank0 top", 32'h003F_FFFF, 4'b0001);
    probe("R8 gap", 32'h0040_0000, 4'b0000);
    probe("R8 bank1 base", 32'h0080_0000, 4'b0010);
    probe("R8 bank1 top", 32'h00FF_FFFF, 4'b0010);
    probe("R8 past bank1", 32'h0100_0000, 4'b0000);
    wreg(8'h48, 32'h000E_0001);
    probe("R9 overlap low", 32'h0000_0000, 4'b0001);
    probe("R9 overlap mid", 32'h0080_0000, 4'b0010);
    probe("R9 big bank", 32'h0040_0000, 4'b0100);
    probe("R8 past big", 32'h2000_0000, 4'b0000);
    wreg(8'h20, 32'h0000_0000);
    probe("R8 global off", 32'h0000_0000, 4'b0000);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule